// File: doc/BRIEF.md
# Locked Instruction Cache Reload Sequencer

This block refills a direct-mapped instruction cache whenever the scheduler dispatches a task, or resumes one after preemption. The scheduler sends a one-cycle task-switch pulse with a word pointer into main memory. At that pointer sits a block-list descriptor. The first word holds the number of entries. The words after it each hold one block number that was chosen offline to stay resident while that task runs.

On a pulse the sequencer first invalidates every cache line, one line per cycle. It then reads the count word. For each entry it makes two memory reads: one for the block number and one for the whole block. The block is written into the line given by direct mapping. When the list is used up, the sequencer raises a one-cycle done pulse. At that moment a cycle counter holds the full refill time, so the dispatch cost can be compared against the schedulability budget. A pulse that arrives while a refill is still running is held and served once the current refill ends.

Top module: `cache_reload_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the first task-switch pulse, busy, done, memReq and fillEn are all 0.
- R2: On the cycle after a task-switch pulse is taken, the sequencer starts invalidating lines. It writes fillEn=1 and fillValid=0 for line indices 0, 1, ... NUM_LINES-1 on consecutive cycles. No memory request is made during this phase.
- R3: Right after the invalidation pass, the sequencer reads the word at the list pointer. Its low LEN_W bits give the entry count. A count of zero ends the refill with no further memory reads.
- R4: Entry i (1-based) takes exactly two reads, in this order: first the word at pointer+i, whose low bits are a block number B, then the block at word address B*LINE_WORDS. memReq stays high with a stable memAddr until memRdy.
- R5: In the cycle the block read gets memRdy, the sequencer writes fillEn=1 and fillValid=1. The line index is B mod NUM_LINES, the tag is B / NUM_LINES, and fillData is the returned line, with word k at bits [WORD_W*k +: WORD_W].
- R6: done is a single-cycle pulse in the cycle after the last fill (or after the count read when the count is zero). At that moment penaltyCycles equals the number of cycles spent working: NUM_LINES, plus every cycle memReq was high.
- R7: A task-switch pulse that arrives while busy is kept pending. If several arrive, the latest pointer wins. The pending refill starts one idle cycle after done, and it starts no second refill.
- R8: busy is high from the cycle after a pulse is taken through the done cycle, and in any cycle where a refill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| taskSwitch | input | 1 | One-cycle pulse when a task starts or resumes |
| listPtr | input | ADDR_W | Word address of the task's block-list descriptor |
| memReq | output | 1 | Memory read request, held until memRdy |
| memAddr | output | ADDR_W | Word address of the read |
| memRdy | input | 1 | Read data valid; completes the request |
| memRdata | input | LINE_W | Line-wide read data starting at memAddr |
| fillEn | output | 1 | Cache line write strobe |
| fillValid | output | 1 | Valid bit written with the line (0 = invalidate) |
| fillIdx | output | IDX_W | Cache line index written |
| fillTag | output | TAG_W | Tag written |
| fillData | output | LINE_W | Line data written |
| busy | output | 1 | Refill running or pending |
| done | output | 1 | One-cycle end-of-refill pulse |
| penaltyCycles | output | CNT_W | Cycles used by the latest refill |

## Verification
The main function is run with four lists: three entries, two of which land on the same line; an empty list; a single entry that hits the top line index; and two entries that map to line 0 and the last line. Comparing these shows the order of address and data reads, that later fills overwrite earlier ones on a shared line, that index and tag split correctly at both ends of the index range, and that an empty list ends right after the count read. Each list is checked against the penalty formula, so a wrong invalidation length or a dropped wait cycle shows up as a cycle-count mismatch. A separate run sends two extra pulses during a refill, which shows that only the latest pending pointer is served.

// File: rtl/reload_pkg.sv
package reload_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_RD_CNT,
    ST_RD_ADDR,
    ST_RD_BLK,
    ST_FINISH
  } seqState_t;

  typedef enum logic {
    MA_LIST,
    MA_BLOCK
  } memSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    start;      // begin a refill
    logic    fromPend;   // take pointer from the pending register
    logic    flushStep;  // invalidate current line, advance index
    logic    capCount;   // latch entry count
    logic    capBlk;     // latch block number
    logic    entryDone;  // one entry filled
    logic    cntRun;     // count a penalty cycle
    memSrc_t memSrc;     // read address source
  } seqCtl_t;

endpackage

// File: rtl/reload_ctrl.sv
module reload_ctrl
  import reload_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    taskSwitch,
  input  logic    pendValid,
  input  logic    flushLast,
  input  logic    countIsZero,
  input  logic    lastEntry,
  input  logic    memRdy,
  output seqCtl_t ctl,
  output logic    memReq,
  output logic    fillEn,
  output logic    fillValid,
  output logic    done,
  output logic    stateBusy
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    memReq    = 1'b0;
    fillEn    = 1'b0;
    fillValid = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendValid) begin
          ctl.start    = 1'b1;
          ctl.fromPend = 1'b1;
          nextState    = ST_FLUSH;
        end else if (taskSwitch) begin
          ctl.start = 1'b1;
          nextState = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        fillEn        = 1'b1;
        ctl.flushStep = 1'b1;
        ctl.cntRun    = 1'b1;
        if (flushLast) nextState = ST_RD_CNT;
      end
      ST_RD_CNT: begin
        memReq     = 1'b1;
        ctl.memSrc = MA_LIST;
        ctl.cntRun = 1'b1;
        if (memRdy) begin
          ctl.capCount = 1'b1;
          nextState    = countIsZero ? ST_FINISH : ST_RD_ADDR;
        end
      end
      ST_RD_ADDR: begin
        memReq     = 1'b1;
        ctl.memSrc = MA_LIST;
        ctl.cntRun = 1'b1;
        if (memRdy) begin
          ctl.capBlk = 1'b1;
          nextState  = ST_RD_BLK;
        end
      end
      ST_RD_BLK: begin
        memReq     = 1'b1;
        ctl.memSrc = MA_BLOCK;
        ctl.cntRun = 1'b1;
        if (memRdy) begin
          fillEn        = 1'b1;
          fillValid     = 1'b1;
          ctl.entryDone = 1'b1;
          nextState     = lastEntry ? ST_FINISH : ST_RD_ADDR;
        end
      end
      ST_FINISH: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign stateBusy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRdy |=> memReq); // R4

  AST_NO_REQ_IN_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    fillEn && !fillValid |-> !memReq); // R2

  AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && taskSwitch |=> fillEn && !fillValid); // R2

endmodule

// File: rtl/reload_dp.sv
module reload_dp
  import reload_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 32,
  parameter int LINE_W    = 128,
  parameter int OFF_W     = 2,
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int BLK_W     = 14,
  parameter int TAG_W     = 10,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              stateBusy,
  input  logic              taskSwitch,
  input  logic [ADDR_W-1:0] listPtr,
  input  logic [LINE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [TAG_W-1:0]  fillTag,
  output logic [LINE_W-1:0] fillData,
  output logic              pendValid,
  output logic              flushLast,
  output logic              countIsZero,
  output logic              lastEntry,
  output logic [CNT_W-1:0]  penaltyCycles
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0]  flushIdx;
  logic [ADDR_W-1:0] listAddr;
  logic [ADDR_W-1:0] pendPtr;
  logic [LEN_W-1:0]  remaining;
  logic [BLK_W-1:0]  blkReg;
  logic [CNT_W-1:0]  cycleCnt;
  logic [WORD_W-1:0] firstWord;

  assign firstWord = memRdata[WORD_W-1:0];

  // pending trigger: latest pointer wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendPtr   <= '0;
    end else if (taskSwitch && (stateBusy || pendValid)) begin
      pendValid <= 1'b1;
      pendPtr   <= listPtr;
    end else if (ctl.start && ctl.fromPend) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushIdx  <= '0;
      listAddr  <= '0;
      remaining <= '0;
      blkReg    <= '0;
    end else begin
      if (ctl.start) begin
        flushIdx <= '0;
        listAddr <= ctl.fromPend ? pendPtr : listPtr;
      end
      if (ctl.flushStep) flushIdx <= flushIdx + 1'b1;
      if (ctl.capCount) begin
        remaining <= firstWord[LEN_W-1:0];
        listAddr  <= listAddr + 1'b1;
      end
      if (ctl.capBlk) begin
        blkReg   <= firstWord[BLK_W-1:0];
        listAddr <= listAddr + 1'b1;
      end
      if (ctl.entryDone) remaining <= remaining - 1'b1;
    end
  end

  // refill penalty: cleared at start, held after finish
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cycleCnt <= '0;
    else if (ctl.start)  cycleCnt <= '0;
    else if (ctl.cntRun) cycleCnt <= cycleCnt + 1'b1;
  end

  assign penaltyCycles = cycleCnt;
  assign flushLast     = (flushIdx == LAST_IDX);
  assign countIsZero   = (firstWord[LEN_W-1:0] == '0);
  assign lastEntry     = (remaining == LEN_W'(1));

  assign memAddr  = (ctl.memSrc == MA_BLOCK) ? {blkReg, {OFF_W{1'b0}}} : listAddr;
  assign fillIdx  = ctl.flushStep ? flushIdx : blkReg[IDX_W-1:0];
  assign fillTag  = ctl.flushStep ? '0 : blkReg[BLK_W-1:IDX_W];
  assign fillData = ctl.flushStep ? '0 : memRdata;

  AST_FLUSH_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flushStep && !flushLast |=> ctl.flushStep && (fillIdx == IDX_W'($past(fillIdx) + 1'b1))); // R2

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && stateBusy |=> pendValid); // R7

  AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.entryDone |-> (remaining != '0)); // R4

  AST_PENALTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stateBusy && !ctl.start |=> $stable(penaltyCycles)); // R6

endmodule

// File: rtl/cache_reload_seq.sv
module cache_reload_seq
  import reload_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 24,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int TAG_W     = BLK_W - IDX_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskSwitch,
  input  logic [ADDR_W-1:0] listPtr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdy,
  input  logic [LINE_W-1:0] memRdata,
  output logic              fillEn,
  output logic              fillValid,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [TAG_W-1:0]  fillTag,
  output logic [LINE_W-1:0] fillData,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  penaltyCycles
);

  seqCtl_t ctl;
  logic    pendValid;
  logic    flushLast;
  logic    countIsZero;
  logic    lastEntry;
  logic    stateBusy;

  reload_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .taskSwitch  (taskSwitch),
    .pendValid   (pendValid),
    .flushLast   (flushLast),
    .countIsZero (countIsZero),
    .lastEntry   (lastEntry),
    .memRdy      (memRdy),
    .ctl         (ctl),
    .memReq      (memReq),
    .fillEn      (fillEn),
    .fillValid   (fillValid),
    .done        (done),
    .stateBusy   (stateBusy)
  );

  reload_dp #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_W    (LINE_W),
    .OFF_W     (OFF_W),
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .BLK_W     (BLK_W),
    .TAG_W     (TAG_W),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .stateBusy     (stateBusy),
    .taskSwitch    (taskSwitch),
    .listPtr       (listPtr),
    .memRdata      (memRdata),
    .memAddr       (memAddr),
    .fillIdx       (fillIdx),
    .fillTag       (fillTag),
    .fillData      (fillData),
    .pendValid     (pendValid),
    .flushLast     (flushLast),
    .countIsZero   (countIsZero),
    .lastEntry     (lastEntry),
    .penaltyCycles (penaltyCycles)
  );

  assign busy = stateBusy || pendValid;

  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R8

  AST_FILL_ON_RDY: assert property (@(posedge clk) disable iff (!rstN)
    fillEn && fillValid |-> memReq && memRdy); // R5

endmodule

// File: tb/cache_reload_seq_bench.sv
module cache_reload_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int WORD_W     = 32;
  localparam int NUM_LINES  = 16;
  localparam int LINE_W     = 128;
  localparam int IDX_W      = 4;
  localparam int TAG_W      = 10;
  localparam int CNT_W      = 24;
  localparam int MEM_LAT    = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 4;
  // stimulus table: list pointer, entry count
  localparam int VEC_PTR [NVEC] = '{0, 8, 12, 16};
  localparam int VEC_CNT [NVEC] = '{3, 0, 1, 2};

  logic              clk = 1'b0;
  logic              rstN;
  logic              taskSwitch;
  logic [ADDR_W-1:0] listPtr;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memRdy;
  logic [LINE_W-1:0] memRdata;
  logic              fillEn;
  logic              fillValid;
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;
  logic [LINE_W-1:0] fillData;
  logic              busy;
  logic              done;
  logic [CNT_W-1:0]  penaltyCycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_reload_seq u_cache_reload_seq (
    .clk(clk), .rstN(rstN), .taskSwitch(taskSwitch), .listPtr(listPtr),
    .memReq(memReq), .memAddr(memAddr), .memRdy(memRdy), .memRdata(memRdata),
    .fillEn(fillEn), .fillValid(fillValid), .fillIdx(fillIdx), .fillTag(fillTag),
    .fillData(fillData), .busy(busy), .done(done), .penaltyCycles(penaltyCycles)
  );

  // memory model
  logic [31:0] mem [256];
  logic [3:0]  waitCnt;
  assign memRdy = memReq && (waitCnt == 4'(MEM_LAT - 1));
  always_comb begin
    for (int k = 0; k < 4; k++) memRdata[k*32 +: 32] = mem[8'(memAddr[7:0] + k)];
  end
  always @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitCnt <= '0;
    else if (memReq && !memRdy)  waitCnt <= waitCnt + 1'b1;
    else                         waitCnt <= '0;
  end

  // monitor, sampled away from the active edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [IDX_W-1:0]  logIdx   [256];
  logic [TAG_W-1:0]  logTag   [256];
  logic              logValid [256];
  logic [LINE_W-1:0] logData  [256];
  int                logCyc   [256];
  int                fillN = 0;
  int                memAddrLog [64];
  int                memCycLog  [64];
  int                memN = 0;
  int                doneCycLog [16];
  int                penLog     [16];
  int                doneN = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (fillEn && fillN < 256) begin
        logIdx[fillN] = fillIdx; logTag[fillN] = fillTag;
        logValid[fillN] = fillValid; logData[fillN] = fillData;
        logCyc[fillN] = cyc; fillN = fillN + 1;
      end
      if (memReq && memRdy && memN < 64) begin
        memAddrLog[memN] = int'(memAddr); memCycLog[memN] = cyc; memN = memN + 1;
      end
      if (done && doneN < 16) begin
        doneCycLog[doneN] = cyc; penLog[doneN] = int'(penaltyCycles); doneN = doneN + 1;
      end
    end
  end

  int  nChecks = 0;
  int  nFails  = 0;
  bit  timedOut = 0;
  int  trigCyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] expLine(input int blk);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = mem[(blk*4 + k) % 256];
    return l;
  endfunction

  task automatic trigger(input int ptr);
    @(negedge clk);
    taskSwitch = 1'b1;
    listPtr    = ADDR_W'(ptr);
    trigCyc    = cyc;
    @(negedge clk);
    taskSwitch = 1'b0;
  endtask

  task automatic waitDones(input int target);
    while (doneN < target && !timedOut) @(negedge clk);
  endtask

  task automatic checkReload(input int ptr, input int fb, input int mb,
                             input int db, input int sc);
    int n, good, pen;
    n = int'(mem[ptr]);
    good = 0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (fb + i < fillN && !logValid[fb+i] && int'(logIdx[fb+i]) == i
          && logCyc[fb+i] == sc + i && good == i) good++;
    end
    chk(good == NUM_LINES, "R2", "invalidation lines in order", good, NUM_LINES);
    chk(memAddrLog[mb] == ptr, "R3", "count read address", memAddrLog[mb], ptr);
    chk(memCycLog[mb] == sc + NUM_LINES + MEM_LAT - 1, "R3", "count read cycle",
        memCycLog[mb], sc + NUM_LINES + MEM_LAT - 1);
    for (int j = 0; j < n; j++) begin
      int b, f;
      b = int'(mem[ptr + 1 + j]);
      f = fb + NUM_LINES + j;
      chk(memAddrLog[mb+1+2*j] == ptr + 1 + j, "R4", "entry address read",
          memAddrLog[mb+1+2*j], ptr + 1 + j);
      chk(memAddrLog[mb+2+2*j] == b*4, "R4", "block read address",
          memAddrLog[mb+2+2*j], b*4);
      chk(logValid[f] && int'(logIdx[f]) == b % NUM_LINES, "R5", "fill line index",
          logIdx[f], b % NUM_LINES);
      chk(int'(logTag[f]) == b / NUM_LINES, "R5", "fill tag", logTag[f], b / NUM_LINES);
      chk(logData[f] == expLine(b), "R5", "fill data low word",
          logData[f][31:0], expLine(b) & 64'hFFFFFFFF);
    end
    chk(fillN == fb + NUM_LINES + n, "R5", "fill count", fillN, fb + NUM_LINES + n);
    chk(memN == mb + 1 + 2*n, "R3", "memory read count", memN, mb + 1 + 2*n);
    pen = NUM_LINES + MEM_LAT * (1 + 2*n);
    chk(doneCycLog[db] == sc + pen, "R6", "done cycle", doneCycLog[db], sc + pen);
    chk(penLog[db] == pen, "R6", "penalty cycles", penLog[db], pen);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h01010101) ^ 32'hA5A50000;
    // list at 0: three entries, 9 and 25 share line 9
    mem[0] = 3;  mem[1] = 9;  mem[2] = 25; mem[3] = 40;
    // list at 8: empty
    mem[8] = 0;
    // list at 12: top line index
    mem[12] = 1; mem[13] = 63;
    // list at 16: line 0 and last line
    mem[16] = 2; mem[17] = 16; mem[18] = 47;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    timedOut = 1;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; taskSwitch = 1'b0; listPtr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReq && !fillEn, "R1", "outputs in reset",
        {busy, done, memReq, fillEn}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReq && !fillEn, "R1", "outputs after reset",
        {busy, done, memReq, fillEn}, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int fb, mb, db;
      fb = fillN; mb = memN; db = doneN;
      chk(int'(mem[VEC_PTR[v]]) == VEC_CNT[v], "R3", "table count word",
          mem[VEC_PTR[v]], VEC_CNT[v]);
      trigger(VEC_PTR[v]);
      chk(busy, "R8", "busy after pulse", busy, 1);
      waitDones(db + 1);
      checkReload(VEC_PTR[v], fb, mb, db, trigCyc + 1);
      @(negedge clk);
      chk(!busy, "R8", "idle after done", busy, 0);
    end

    // pending triggers: latest pointer wins
    begin
      int fb, mb, db, sc;
      fb = fillN; mb = memN; db = doneN;
      trigger(0);
      sc = trigCyc + 1;
      repeat (20) @(negedge clk);
      trigger(12);
      repeat (5) @(negedge clk);
      trigger(16);
      waitDones(db + 1);
      checkReload(0, fb, mb, db, sc);
      @(negedge clk);
      chk(busy, "R7", "busy while refill pending", busy, 1);
      waitDones(db + 2);
      checkReload(16, fb + NUM_LINES + 3, mb + 7, db + 1, doneCycLog[db] + 2);
      repeat (60) @(negedge clk);
      chk(doneN == db + 2, "R7", "only latest pending pointer served", doneN, db + 2);
      chk(!busy, "R8", "idle after pending served", busy, 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule